// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. A single-cycle enable, pulsed once per second by an external divider, advances seconds. Rollovers then ripple through minutes, hours, day of week, date, month and a two-digit year. Everything up to the year moves in that one clock cycle. Hours run either as 00–23 or as 01–12 with an AM/PM flag, and the mode is chosen by a bit stored inside the hours byte. The date rolls over at the true length of each month, and February gains a 29th day in years whose value is a multiple of four.

A host loads any register through a write port. A write always beats the increment landing on that register in the same cycle. A combinational read port returns any register by index. Index map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01, year 0x00.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. On a tick, seconds advance. From 0x59 they return to 0x00 and advance minutes. Minutes at 0x59 that are advanced return to 0x00 and advance hours. Without a tick or a write, no register changes.
- R3: With hours bit 7 clear, hours count 0x00 to 0x23. Advancing past 0x23 gives 0x00 and advances the day.
- R4: With hours bit 7 set, bits 4:0 hold the BCD hour 01–12 and bit 5 holds PM. Moving from 11 to 12 toggles PM. Moving from 12 to 01 keeps PM. Only the move from 11 PM to 12 AM advances the day.
- R5: Day of week counts 1 to 7 and wraps from 7 to 1. It advances on the same hour rollover as the date.
- R6: When the date is advanced at or past the last day of the current month, it becomes 0x01 and the month advances. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other non-February months.
- R7: The last day of February (month 0x02) is 0x29 when the year value is divisible by 4, and 0x28 otherwise.
- R8: Month counts 0x01 to 0x12. Advancing 0x12 gives 0x01 and advances the year. Year counts 0x00 to 0x99 and wraps to 0x00.
- R9: A write loads the addressed register in the next cycle, even when a tick or carry would change it in that cycle. A register being written passes no carry on to the registers after it.
- R10: The read port returns the register at indices 0–6 and returns 0x00 at index 7. A write to index 7 changes nothing.
- R11: A written hours value has bit 6 forced to 0. All other bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index for writes |
| wr_data_i | input | 8 | Packed BCD value to load |
| rd_addr_i | input | 3 | Register index for reads |
| rd_data_o | output | 8 | Packed BCD value of the selected register |

## Verification
The bench builds the block with its default index width of 3 bits. All seven registers plus the unused eighth index are then reachable for both writes and reads. Random writes bias seconds, minutes, hours, dates and months toward their last values, so that the full carry chain can be reached. With that bias, rollovers of day, month, year and leap February come within a handful of ticks rather than days of simulated time. Directed cases pin down the 12-hour PM edges, the leap and non-leap February ends, the century wrap and a write colliding with a carry.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // value mod 4 == (2*tens + units) mod 4
  function automatic logic leap_year(input logic [7:0] y);
    logic [3:0] s;
    s = y[3:0] + {2'b00, y[4], 1'b0};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic [7:0] last_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [7:0] val_q;
  logic       at_end;

  assign at_end = (val_q >= last_i);
  assign wrap_o = inc_i & ~ld_i & at_end;
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= FIRST;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_end ? FIRST : bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] hour_o,
  output logic       day_o
);
  logic [7:0] hour_q, nxt, d12, d24, inc12;
  logic       mode12, pm;

  assign mode12 = hour_q[7];
  assign pm     = hour_q[5];
  assign d12    = {3'b000, hour_q[4:0]};
  assign d24    = {2'b00, hour_q[5:0]};
  assign inc12  = bcd_inc(d12);

  always_comb begin
    if (mode12) begin
      if (d12 == 8'h11)      nxt = {2'b10, ~pm, 5'h12};
      else if (d12 >= 8'h12) nxt = {2'b10, pm, 5'h01};
      else                   nxt = {2'b10, pm, inc12[4:0]};
    end else begin
      nxt = (d24 >= 8'h23) ? 8'h00 : bcd_inc(d24);
    end
  end

  assign day_o  = inc_i & ~ld_i & (mode12 ? (d12 == 8'h11 && pm) : (d24 >= 8'h23));
  assign hour_o = hour_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hour_q <= 8'h00;
    else if (ld_i)  hour_q <= ld_val_i & 8'hBF;
    else if (inc_i) hour_q <= nxt;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int unsigned NREG = 7;

  logic [NREG-1:0] ld;
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
  logic sec_c, min_c, day_c, dow_c, date_c, month_c, year_c;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign ld[k] = wr_en_i && (wr_addr_i == AW'(k));
  end

  rtc_bcd_ctr #(.FIRST(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_i), .ld_i(ld[SEL_SEC]), .ld_val_i(wr_data_i),
    .last_i(8'h59), .val_o(sec_q), .wrap_o(sec_c));

  rtc_bcd_ctr #(.FIRST(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_c), .ld_i(ld[SEL_MIN]), .ld_val_i(wr_data_i),
    .last_i(8'h59), .val_o(min_q), .wrap_o(min_c));

  rtc_hour_ctr u_hour (
    .clk_i, .rst_ni, .inc_i(min_c), .ld_i(ld[SEL_HOUR]), .ld_val_i(wr_data_i),
    .hour_o(hour_q), .day_o(day_c));

  rtc_bcd_ctr #(.FIRST(8'h01)) u_dow (
    .clk_i, .rst_ni, .inc_i(day_c), .ld_i(ld[SEL_DOW]), .ld_val_i(wr_data_i),
    .last_i(8'h07), .val_o(dow_q), .wrap_o(dow_c));

  rtc_bcd_ctr #(.FIRST(8'h01)) u_date (
    .clk_i, .rst_ni, .inc_i(day_c), .ld_i(ld[SEL_DATE]), .ld_val_i(wr_data_i),
    .last_i(last_date(month_q, year_q)), .val_o(date_q), .wrap_o(date_c));

  rtc_bcd_ctr #(.FIRST(8'h01)) u_month (
    .clk_i, .rst_ni, .inc_i(date_c), .ld_i(ld[SEL_MONTH]), .ld_val_i(wr_data_i),
    .last_i(8'h12), .val_o(month_q), .wrap_o(month_c));

  rtc_bcd_ctr #(.FIRST(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(month_c), .ld_i(ld[SEL_YEAR]), .ld_val_i(wr_data_i),
    .last_i(8'h99), .val_o(year_q), .wrap_o(year_c));

  always_comb begin
    case (rd_addr_i)
      AW'(SEL_SEC):   rd_data_o = sec_q;
      AW'(SEL_MIN):   rd_data_o = min_q;
      AW'(SEL_HOUR):  rd_data_o = hour_q;
      AW'(SEL_DOW):   rd_data_o = dow_q;
      AW'(SEL_DATE):  rd_data_o = date_q;
      AW'(SEL_MONTH): rd_data_o = month_q;
      AW'(SEL_YEAR):  rd_data_o = year_q;
      default:        rd_data_o = 8'h00;
    endcase
  end

  logic unused_c;
  assign unused_c = dow_c ^ year_c;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [7:0] hour_i,
  input logic [7:0] dow_i,
  input logic [7:0] date_i,
  input logic [7:0] month_i,
  input logic [7:0] year_i
);
  logic top_of_hour;
  assign top_of_hour = tick_i && !wr_en_i && sec_i == 8'h59 && min_i == 8'h59;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_en_i |=> $stable(sec_i) && $stable(min_i) && $stable(hour_i) &&
      $stable(dow_i) && $stable(date_i) && $stable(month_i) && $stable(year_i));

  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i && sec_i == 8'h59 |=> sec_i == 8'h00);

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 3'd0 |=> sec_i == $past(wr_data_i));

  p_pm_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_of_hour && hour_i == 8'h91 |=> hour_i == 8'hB2);

  p_dow_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_of_hour && hour_i == 8'h23 && dow_i == 8'h07 |=> dow_i == 8'h01);

  p_year_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_of_hour && hour_i == 8'h23 && date_i == 8'h31 && month_i == 8'h12 && year_i == 8'h99
    |=> year_i == 8'h00 && month_i == 8'h01);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .sec_i(sec_q), .min_i(min_q), .hour_i(hour_q), .dow_i(dow_q),
  .date_i(date_q), .month_i(month_q), .year_i(year_q));

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0;
  logic [2:0] wa = '0, ra = '0;
  logic [7:0] wd = '0, rd;
  int vec = 0, bad = 0;
  bit done = 0;

  // reference state (binary)
  int sec, mn, hr, dw, dt, mo, yr;
  bit m12, pm;

  always #4 clk = ~clk;

  rtc_calendar u_dut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd));

  function automatic logic [7:0] tobcd(int v); return 8'((v / 10) * 16 + v % 10); endfunction
  function automatic int frombcd(logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expv(int a);
    case (a)
      0: return tobcd(sec);
      1: return tobcd(mn);
      2: return m12 ? {2'b10, pm, tobcd(hr)[4:0]} : tobcd(hr);
      3: return tobcd(dw);
      4: return tobcd(dt);
      5: return tobcd(mo);
      6: return tobcd(yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rq(int a);
    case (a)
      0, 1: return "R2";
      2: return m12 ? "R4" : "R3";
      3: return "R5";
      4: return (mo == 2) ? "R7" : "R6";
      5, 6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply_write(int a, logic [7:0] d);
    case (a)
      0: sec = frombcd(d);
      1: mn = frombcd(d);
      2: begin m12 = d[7]; pm = d[7] & d[5]; hr = d[7] ? frombcd({3'b0, d[4:0]}) : frombcd({2'b0, d[5:0]}); end
      3: dw = frombcd(d);
      4: dt = frombcd(d);
      5: mo = frombcd(d);
      6: yr = frombcd(d);
      default: ;
    endcase
  endtask

  // R9: a written level absorbs the carry
  task automatic model_step(bit t, bit w, int a, logic [7:0] d);
    bit c;
    if (t) begin
      c = 1;
      if (w && a == 0) c = 0; else begin sec++; if (sec >= 60) sec = 0; else c = 0; end
      if (c) begin if (w && a == 1) c = 0; else begin mn++; if (mn >= 60) mn = 0; else c = 0; end end
      if (c) begin
        if (w && a == 2) c = 0;
        else if (m12) begin
          if (hr == 11) begin c = pm; hr = 12; pm = !pm; end
          else begin c = 0; hr = (hr == 12) ? 1 : hr + 1; end
        end else begin hr++; if (hr >= 24) hr = 0; else c = 0; end
      end
      if (c) begin
        if (!(w && a == 3)) dw = (dw >= 7) ? 1 : dw + 1;
        if (w && a == 4) c = 0; else begin dt++; if (dt > mlen(mo, yr)) dt = 1; else c = 0; end
      end
      if (c) begin if (w && a == 5) c = 0; else begin mo++; if (mo > 12) mo = 1; else c = 0; end end
      if (c && !(w && a == 6)) yr = (yr + 1) % 100;
    end
    if (w) apply_write(a, d);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 8; a++) begin
      ra = 3'(a);
      #0.4;
      vec++;
      if (rd !== expv(a)) begin
        bad++;
        $display("FAIL %s %s idx%0d got %h exp %h", rq(a), tag, a, rd, expv(a));
      end
    end
  endtask

  task automatic cyc(bit t, bit w, int a, logic [7:0] d, string tag);
    @(negedge clk);
    tick = t; we = w; wa = 3'(a); wd = d;
    @(posedge clk);
    model_step(t, w, a, d);
    #0.5;
    tick = 0; we = 0;
    check_all(tag);
  endtask

  task automatic load(int s, int m, logic [7:0] h, int w, int d, int mth, int y);
    cyc(0, 1, 0, tobcd(s), "ld");  cyc(0, 1, 1, tobcd(m), "ld");
    cyc(0, 1, 2, h, "ld");         cyc(0, 1, 3, tobcd(w), "ld");
    cyc(0, 1, 5, tobcd(mth), "ld"); cyc(0, 1, 6, tobcd(y), "ld");
    cyc(0, 1, 4, tobcd(d), "ld");
  endtask

  function automatic logic [7:0] rnd_val(int a);
    int v;
    bit b;
    b = ($urandom % 3) != 0;
    case (a)
      0, 1: v = b ? 59 - $urandom % 2 : $urandom % 60;
      2: begin
        if ($urandom % 2) begin
          v = b ? 11 + $urandom % 2 : 1 + $urandom % 12;
          return {2'b10, 1'($urandom % 2), tobcd(v)[4:0]};
        end
        v = b ? 23 : $urandom % 24;
      end
      3: v = 1 + $urandom % 7;
      4: v = b ? mlen(mo, yr) : 1 + $urandom % 28;
      5: v = b ? (($urandom % 2) ? 12 : 2) : 1 + $urandom % 12;
      6: v = b ? (($urandom % 2) ? 99 : 3 + $urandom % 2) : $urandom % 100;
      default: v = $urandom % 100;
    endcase
    return tobcd(v);
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    sec = 0; mn = 0; hr = 0; m12 = 0; pm = 0; dw = 1; dt = 1; mo = 1; yr = 0;
    #20 rst_n = 1;
    #1 check_all("R1 reset");

    // R2 simple counting, R2 idle hold
    cyc(1, 0, 0, 0, "R2 tick"); cyc(0, 0, 0, 0, "R2 idle");
    // R3 24h day rollover, R5 dow 7->1
    load(59, 59, 8'h23, 7, 15, 6, 10); cyc(1, 0, 0, 0, "R3 R5 midnight");
    // R4 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM day advance
    load(59, 59, 8'h91, 2, 10, 3, 5); cyc(1, 0, 0, 0, "R4 am-pm");
    load(59, 59, 8'hB2, 2, 10, 3, 5); cyc(1, 0, 0, 0, "R4 12pm-1pm");
    load(59, 59, 8'hB1, 2, 10, 3, 5); cyc(1, 0, 0, 0, "R4 11pm-12am");
    load(59, 59, 8'h92, 2, 10, 3, 5); cyc(1, 0, 0, 0, "R4 12am-1am");
    // R6 30-day month, R7 leap/non-leap Feb
    load(59, 59, 8'h23, 3, 30, 4, 7); cyc(1, 0, 0, 0, "R6 apr30");
    load(59, 59, 8'h23, 3, 28, 2, 23); cyc(1, 0, 0, 0, "R7 feb28 nonleap");
    load(59, 59, 8'h23, 3, 28, 2, 24); cyc(1, 0, 0, 0, "R7 feb28 leap");
    cyc(0, 1, 0, 8'h59, "R7"); cyc(0, 1, 1, 8'h59, "R7");
    cyc(0, 1, 2, 8'h23, "R7"); cyc(1, 0, 0, 0, "R7 feb29 leap");
    // R8 century wrap
    load(59, 59, 8'h23, 4, 31, 12, 99); cyc(1, 0, 0, 0, "R8 new century");
    // R9 write beats carry
    load(59, 59, 8'h23, 4, 31, 12, 99); cyc(1, 1, 1, 8'h30, "R9 collide min");
    load(59, 59, 8'h23, 4, 31, 12, 99); cyc(1, 1, 0, 8'h12, "R9 collide sec");
    // R10 index 7 ignored, R11 bit 6 masked
    cyc(0, 1, 7, 8'h55, "R10 idx7");
    cyc(0, 1, 2, 8'hD1, "R11 mask"); cyc(0, 1, 2, 8'h45, "R11 mask");

    for (int i = 0; i < 6000; i++) begin
      int a;
      bit w;
      a = $urandom % 8;
      w = ($urandom % 4) == 0;
      cyc(1'($urandom % 2), w, a, w ? rnd_val(a) : 8'h00, "rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule